// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block takes single memory requests from a processor-side port and turns each one into the short series of DRAM commands it needs. A flat request address is cut into column, bank and row fields. Every bank keeps its last activated row open after an access, so a later request to the same row of that bank needs only a column command. A request to a bank with no open row needs an activate first. A request to a bank that holds a different row first closes that row with a precharge.

Row and column addresses share one multiplexed address bus. The row goes out with an activate and the column goes out with a read or a write. Each bank has its own countdown counters for the activate-to-column gap, the precharge-to-activate gap and the minimum time a row must stay active. A command is placed on the bus only when the counter that guards it has run out. In every other cycle the bus carries a no-operation code. Read data comes back from the DRAM a fixed CAS latency after the read command and is handed to the requester with a one-cycle strobe.

Top module: `dram_bank_seq`

## Requirements
- R1: The request address is split with the column in bits [COL_W-1:0], the bank in the next BANK_W bits and the row in the top ROW_W bits.
- R2: A request to a bank with no open row produces an activate carrying the row on cmd_addr, then a read or write carrying the zero-extended column on cmd_addr, both with cmd_bank set to the bank.
- R3: A request that hits the open row of its bank produces only the column command, with no activate or precharge. If the bank's timers have expired, that command appears in the cycle after the request is accepted.
- R4: A request to a bank holding a different open row produces a precharge, then an activate, then the column command.
- R5: Banks keep their open rows independently, so an access to one bank never precharges or reopens another.
- R6: Within one bank, an activate is followed by a column command no sooner than T_RCD cycles later and by a precharge no sooner than T_RAS cycles later. A precharge is followed by an activate no sooner than T_RP cycles later.
- R7: At most one command is driven per cycle, with the encoding NOP=0, ACT=1, RD=2, WR=3, PRE=4. When no command is issued, cmd_code is NOP.
- R8: The DRAM drives read data on dram_rdata CAS_LAT cycles after the read command. In the following cycle rsp_valid pulses high for exactly one cycle and rsp_data carries that data.
- R9: req_ready is high only while no request is in progress, and a request is taken when req_valid and req_ready are both high. req_ready stays low from the next cycle until the request's column command has been issued, and no command is issued while req_ready is high. A write's data is driven on cmd_wdata alongside the WR command.
- R10: After reset, cmd_code is NOP, req_ready is high, rsp_valid is low and all banks are closed, so the first access to any bank begins with an activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Flat address {row, bank, column} |
| req_wdata | input | DATA_W | Write data |
| cmd_code | output | 3 | DRAM command code |
| cmd_bank | output | BANK_W | Bank addressed by the command |
| cmd_addr | output | MUX_W | Row (activate) or column (read/write) address |
| cmd_wdata | output | DATA_W | Write data, valid with WR |
| dram_rdata | input | DATA_W | Read data returned by the DRAM |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | DATA_W | Read response data |

## Verification
The read response of one request can arrive in the same cycle that the command for the next request is issued, because the CAS latency is longer than the two-cycle turnaround of a row hit. The bench provokes this with back-to-back reads that hit an open row, followed by a read that misses. A scoreboard matches every command against the open-row model built by the driver. A separate scoreboard matches every response strobe against the data queue and against the cycle of its read command plus CAS_LAT plus one. A bank-timing model checks the per-bank gaps on every command, so an overlap that corrupts either stream shows up as a mismatch.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } cmd_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SEQ  = 1'b1
   } seq_st_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/bank_timer.sv
module bank_timer import dram_seq_pkg::*; #(
   parameter int ROW_W = 4,
   parameter int T_RCD = 3,
   parameter int T_RP  = 3,
   parameter int T_RAS = 6,
   localparam int CNT_W = $clog2(max2(max2(T_RCD, T_RP), T_RAS) + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_act,
   input  logic             do_pre,
   input  logic [ROW_W-1:0] act_row,
   output logic             is_open,
   output logic [ROW_W-1:0] open_row,
   output logic             act_ok,
   output logic             col_ok,
   output logic             pre_ok
);
   logic [CNT_W-1:0] rcd_cnt, rp_cnt, ras_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open  <= 1'b0;
         open_row <= '0;
         rcd_cnt  <= '0;
         rp_cnt   <= '0;
         ras_cnt  <= '0;
      end else begin
         if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
         if (rp_cnt  != '0) rp_cnt  <= rp_cnt  - 1'b1;
         if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
         if (do_act) begin
            is_open  <= 1'b1;
            open_row <= act_row;
            rcd_cnt  <= CNT_W'(T_RCD - 1);
            ras_cnt  <= CNT_W'(T_RAS - 1);
         end
         if (do_pre) begin
            is_open <= 1'b0;
            rp_cnt  <= CNT_W'(T_RP - 1);
         end
      end
   end

   assign act_ok = (rp_cnt  == '0);
   assign col_ok = (rcd_cnt == '0);
   assign pre_ok = (ras_cnt == '0);
endmodule

// File: rtl/rd_return.sv
module rd_return #(
   parameter int DATA_W = 8,
   parameter int LAT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_issue,
   input  logic [DATA_W-1:0] dram_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);
   logic tap;

   generate
      if (LAT == 1) begin : g_lat1
         logic stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= rd_issue;
         end
         assign tap = stage_q;
      end else begin : g_latn
         logic [LAT-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= {stage_q[LAT-2:0], rd_issue};
         end
         assign tap = stage_q[LAT-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= tap;
         if (tap) rsp_data <= dram_rdata;
      end
   end
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq import dram_seq_pkg::*; #(
   parameter int BANKS   = 4,
   parameter int ROW_W   = 4,
   parameter int COL_W   = 3,
   parameter int DATA_W  = 8,
   parameter int T_RCD   = 3,
   parameter int T_RP    = 3,
   parameter int T_RAS   = 6,
   parameter int CAS_LAT = 3,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ADDR_W = ROW_W + BANK_W + COL_W,
   localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [2:0]        cmd_code,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [MUX_W-1:0]  cmd_addr,
   output logic [DATA_W-1:0] cmd_wdata,
   input  logic [DATA_W-1:0] dram_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);
   // elaboration-time parameter checks
   generate
      if (!(BANKS == 4 || BANKS == 8)) begin : g_bad_banks
         $error("dram_bank_seq: BANKS must be 4 or 8");
      end
      if (T_RCD < 1 || T_RP < 1 || T_RAS < 1 || CAS_LAT < 1) begin : g_bad_timing
         $error("dram_bank_seq: timing parameters must be at least 1");
      end
   endgenerate

   seq_st_e           state;
   logic              lat_write;
   logic [BANK_W-1:0] lat_bank;
   logic [ROW_W-1:0]  lat_row;
   logic [COL_W-1:0]  lat_col;
   logic [DATA_W-1:0] lat_wdata;

   logic [BANKS-1:0]  b_open, b_act_ok, b_col_ok, b_pre_ok;
   logic [ROW_W-1:0]  b_row [BANKS];
   logic              issue_act, issue_pre, issue_col;
   cmd_e              cmd;

   generate
      for (genvar i = 0; i < BANKS; i++) begin : g_bank
         bank_timer #(
            .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
         ) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .do_act  (issue_act && (lat_bank == BANK_W'(i))),
            .do_pre  (issue_pre && (lat_bank == BANK_W'(i))),
            .act_row (lat_row),
            .is_open (b_open[i]),
            .open_row(b_row[i]),
            .act_ok  (b_act_ok[i]),
            .col_ok  (b_col_ok[i]),
            .pre_ok  (b_pre_ok[i])
         );
      end
   endgenerate

   // command selection for the request in progress
   always_comb begin
      cmd       = CMD_NOP;
      cmd_addr  = '0;
      issue_act = 1'b0;
      issue_pre = 1'b0;
      issue_col = 1'b0;
      if (state == ST_SEQ) begin
         if (b_open[lat_bank]) begin
            if (b_row[lat_bank] == lat_row) begin
               if (b_col_ok[lat_bank]) begin
                  issue_col = 1'b1;
                  cmd       = lat_write ? CMD_WR : CMD_RD;
                  cmd_addr  = MUX_W'(lat_col);
               end
            end else if (b_pre_ok[lat_bank]) begin
               issue_pre = 1'b1;
               cmd       = CMD_PRE;
            end
         end else if (b_act_ok[lat_bank]) begin
            issue_act = 1'b1;
            cmd       = CMD_ACT;
            cmd_addr  = MUX_W'(lat_row);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lat_write <= 1'b0;
         lat_bank  <= '0;
         lat_row   <= '0;
         lat_col   <= '0;
         lat_wdata <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               state     <= ST_SEQ;
               lat_write <= req_write;
               lat_col   <= req_addr[COL_W-1:0];
               lat_bank  <= req_addr[COL_W +: BANK_W];
               lat_row   <= req_addr[COL_W+BANK_W +: ROW_W];
               lat_wdata <= req_wdata;
            end
            ST_SEQ: if (issue_col) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign cmd_code  = cmd;
   assign cmd_bank  = lat_bank;
   assign cmd_wdata = lat_wdata;

   rd_return #(.DATA_W(DATA_W), .LAT(CAS_LAT)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_issue  (issue_col && !lat_write),
      .dram_rdata(dram_rdata),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data)
   );
endmodule

// File: rtl/dram_bank_seq_chk.sv
module dram_bank_seq_chk #(
   parameter int T_RCD = 3,
   parameter int T_RP  = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [2:0] cmd_code,
   input logic       rsp_valid
);
   p_legal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_code <= 3'd4);

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> cmd_code == 3'd0);

   p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_ready_after_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == 3'd2 || cmd_code == 3'd3) |=> req_ready);

   p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   generate
      if (T_RCD > 1) begin : g_rcd
         p_rcd_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_code == 3'd1 |=> !(cmd_code == 3'd2 || cmd_code == 3'd3));
      end
      if (T_RP > 1) begin : g_rp
         p_rp_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_code == 3'd4 |=> cmd_code != 3'd1);
      end
   endgenerate
endmodule

bind dram_bank_seq dram_bank_seq_chk #(.T_RCD(T_RCD), .T_RP(T_RP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .cmd_code (cmd_code),
   .rsp_valid(rsp_valid)
);

// File: tb/tb_dram_bank_seq.sv
module tb_dram_bank_seq;
   localparam int BANKS = 4, ROW_W = 4, COL_W = 3, DATA_W = 8;
   localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, CAS_LAT = 3;
   localparam int BANK_W = 2, ADDR_W = ROW_W + BANK_W + COL_W, MUX_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0, dram_rdata = '0;
   logic req_ready, rsp_valid;
   logic [2:0] cmd_code;
   logic [BANK_W-1:0] cmd_bank;
   logic [MUX_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_wdata, rsp_data;

   always #10 clk = ~clk;

   dram_bank_seq #(.BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .CAS_LAT(CAS_LAT)) dut (.*);

   typedef struct { int kind; int bank; int addr; int wdata; int must; } exp_t;
   exp_t exp_cmd[$];
   int   exp_rd[$];
   int   rd_cyc[$];
   int   due_cyc[$];
   int   due_dat[$];

   int cyc = 0, n_chk = 0, n_bad = 0;
   bit done = 0;
   int model_open[BANKS];
   int model_row[BANKS];
   int shadow[int];
   int dmem[int];
   int last_act[BANKS], last_pre[BANKS];
   int dram_row[BANKS];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // driver: builds expected command and read-data streams from its own open-row model
   task automatic do_req(input bit wr, input int bank, input int row, input int col,
                         input int wd, input bit fast);
      int addr;
      exp_t e;
      addr = (row << (COL_W + BANK_W)) | (bank << COL_W) | col;   // R1 field layout
      @(negedge clk);
      req_valid = 1'b1; req_write = wr;
      req_addr = ADDR_W'(addr); req_wdata = DATA_W'(wd);
      while (!req_ready) @(negedge clk);
      if (model_open[bank] && model_row[bank] != row) begin
         e = '{4, bank, -1, 0, -1}; exp_cmd.push_back(e);
         model_open[bank] = 0;
      end
      if (!model_open[bank]) begin
         e = '{1, bank, row, 0, -1}; exp_cmd.push_back(e);
         model_open[bank] = 1; model_row[bank] = row;
      end
      e = '{wr ? 3 : 2, bank, col, wd, fast ? cyc + 1 : -1};
      exp_cmd.push_back(e);
      if (wr) shadow[addr] = wd;
      else exp_rd.push_back(shadow.exists(addr) ? shadow[addr] : 0);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: command scoreboard, DRAM timing model, read data return
   always @(negedge clk) begin
      if (rst_n) begin
         dram_rdata <= '0;
         if (due_cyc.size() > 0 && due_cyc[0] == cyc) begin
            dram_rdata <= DATA_W'(due_dat[0]);
            void'(due_cyc.pop_front()); void'(due_dat.pop_front());
         end
         if (cmd_code != 3'd0) begin
            int b;
            b = int'(cmd_bank);
            check(cmd_code <= 3'd4, "R7", "command code", cmd_code, 0);
            if (exp_cmd.size() == 0) check(0, "R7", "unexpected command", cmd_code, 0);
            else begin
               exp_t e;
               e = exp_cmd.pop_front();
               check(int'(cmd_code) == e.kind, "R2/R3/R4/R5", "command kind", cmd_code, e.kind);
               check(b == e.bank, "R1", "command bank", b, e.bank);
               if (e.addr >= 0) check(int'(cmd_addr) == e.addr, "R1/R2", "command address", cmd_addr, e.addr);
               if (e.kind == 3) check(int'(cmd_wdata) == e.wdata, "R9", "write data", cmd_wdata, e.wdata);
               if (e.must >= 0) check(cyc == e.must, "R3", "hit command cycle", cyc, e.must);
            end
            case (cmd_code)
               3'd1: begin
                  check(cyc - last_pre[b] >= T_RP, "R6", "precharge-to-activate gap", cyc - last_pre[b], T_RP);
                  check(dram_row[b] < 0, "R4", "activate on open bank", dram_row[b], -1);
                  last_act[b] = cyc; dram_row[b] = int'(cmd_addr);
               end
               3'd2, 3'd3: begin
                  check(cyc - last_act[b] >= T_RCD, "R6", "activate-to-column gap", cyc - last_act[b], T_RCD);
                  if (cmd_code == 3'd3) dmem[b*1024 + dram_row[b]*16 + int'(cmd_addr)] = int'(cmd_wdata);
                  else begin
                     int k;
                     k = b*1024 + dram_row[b]*16 + int'(cmd_addr);
                     due_cyc.push_back(cyc + CAS_LAT);
                     due_dat.push_back(dmem.exists(k) ? dmem[k] : 0);
                     rd_cyc.push_back(cyc);
                  end
               end
               3'd4: begin
                  check(cyc - last_act[b] >= T_RAS, "R6", "activate-to-precharge gap", cyc - last_act[b], T_RAS);
                  last_pre[b] = cyc; dram_row[b] = -1;
               end
               default: ;
            endcase
         end
         if (rsp_valid) begin
            if (exp_rd.size() == 0) check(0, "R8", "unexpected response", rsp_data, 0);
            else begin
               int ev, rc;
               ev = exp_rd.pop_front();
               rc = rd_cyc.pop_front();
               check(int'(rsp_data) == ev, "R8", "read data", rsp_data, ev);
               check(cyc == rc + CAS_LAT + 1, "R8", "response cycle", cyc, rc + CAS_LAT + 1);
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < BANKS; i++) begin
         model_open[i] = 0; last_act[i] = -1000; last_pre[i] = -1000; dram_row[i] = -1;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check(cmd_code == 3'd0, "R10", "command after reset", cmd_code, 0);
      check(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
      check(rsp_valid == 1'b0, "R10", "response after reset", rsp_valid, 0);
      // R2: closed bank, R3: hit, R8: read back
      do_req(1, 0, 1, 2, 8'h5a, 0);
      do_req(0, 0, 1, 2, 0, 1);
      do_req(1, 0, 1, 5, 8'hc3, 1);
      // back-to-back hit reads: responses overlap next commands
      do_req(0, 0, 1, 5, 0, 1);
      do_req(0, 0, 1, 2, 0, 1);
      // R5: other bank opens without disturbing bank 0
      do_req(1, 1, 5, 0, 8'h11, 0);
      do_req(0, 0, 1, 5, 0, 1);
      // R4: miss on open bank, right after reads in flight
      do_req(0, 0, 7, 3, 0, 0);
      // R6: miss immediately after activate, precharge must wait
      do_req(1, 2, 3, 1, 8'h77, 0);
      do_req(0, 2, 4, 1, 0, 0);
      do_req(0, 2, 3, 1, 0, 0);
      do_req(0, 1, 5, 0, 0, 0);
      // mixed stream
      begin
         logic [15:0] lf;
         lf = 16'hace1;
         for (int n = 0; n < 60; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_req(lf[0], int'(lf[2:1]), int'(lf[3]) + 2, int'(lf[6:4]), int'(lf[14:7]), 0);
         end
      end
      repeat (20) @(negedge clk);
      check(exp_cmd.size() == 0, "R9", "commands outstanding", exp_cmd.size(), 0);
      check(exp_rd.size() == 0, "R8", "responses outstanding", exp_rd.size(), 0);
      check(req_ready == 1'b1, "R9", "ready when drained", req_ready, 1);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule